// File: doc/BRIEF.md
# Limited-Pointer Coherence Directory Entry with Software Overflow

This block is the controller for one directory entry of a distributed shared-memory home node. It records the nodes that hold a copy of the line in a small, fixed set of hardware pointer slots. Each slot holds a node identifier plus a valid bit. Reads, writes and recalls of an owned line are handled entirely in hardware while the sharer set fits in the slots.

When a new reader would need one more slot than exists, the entry stops serving the request. It raises a trap request to a local processor, which sees the request kind, the requester and every stored pointer. The entry then stays in a transitional meta-state and refuses all traffic until the handler signals completion. After that the hardware slots are empty again and the entry is marked so that reads continue in hardware while every write is handed to software. Software reports how many invalidations it has sent. The entry counts the returning acknowledgements and only then grants write permission. The hardware write path works the same way: the entry sends invalidations itself, one per cycle, and holds the grant until the last acknowledgement has arrived.

Top module: `lpdir_entry`

## Requirements
- R1: After reset, rsp_valid, inv_valid and trap_valid are low, meta_state is 0 (normal) and line_rw is 0.
- R2: A read of a line that is not owned, from a node already recorded or arriving while a slot is free, gives rsp_kind 0 (read data) to that node in the cycle after the request. A new node takes the lowest free slot.
- R3: A read from an unrecorded node while all HW_PTRS slots are valid gives no data reply. From the next cycle on, trap_valid is high with trap_write 0, the requester on trap_src, slot i on trap_ptrs[i*ID_W +: ID_W], all trap_ptr_vld bits set, and meta_state 1 (in transition).
- R4: Any request that arrives while meta_state is 1, or while write acknowledgements are outstanding, is answered in the next cycle with rsp_kind 2 (retry) to that requester and changes no state.
- R5: trap_done, accepted in a cycle with no incoming request, completes a read trap. trap_valid drops, rsp_kind 0 goes to the saved requester in the next cycle, all slots are emptied and meta_state becomes 2 (writes trapped).
- R6: With meta_state 2, reads are served by hardware as in R2 and meta_state stays 2. A write raises a trap with trap_write 1 and meta_state 1.
- R7: A write handled in hardware sends one invalidation per cycle on inv_valid/inv_dst to every recorded node except the requester, lowest slot first. The acknowledgement counter is loaded with the number of such nodes.
- R8: Write permission (rsp_kind 1) is issued only after all invalidations have been sent and the acknowledgement count has reached zero. After the grant, line_rw is 1 and the requester is the only recorded node.
- R9: trap_done on a write trap loads the acknowledgement counter from trap_inv_cnt and returns meta_state to 0. Write permission to the saved requester follows that many ack_valid pulses.
- R10: A request from a non-owner to an owned line invalidates the owner and waits for its acknowledgement. A read then gets rsp_kind 0 and leaves line_rw 0 with the reader recorded. A request from the owner itself is granted in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Incoming request strobe |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_src | input | ID_W | Requesting node |
| rsp_valid | output | 1 | Reply strobe |
| rsp_kind | output | 2 | 0 read data, 1 write permission, 2 retry |
| rsp_dst | output | ID_W | Reply destination |
| inv_valid | output | 1 | Invalidation strobe |
| inv_dst | output | ID_W | Node to invalidate |
| ack_valid | input | 1 | One invalidation acknowledgement |
| trap_valid | output | 1 | Trap request to the local processor |
| trap_write | output | 1 | Trapped request was a write |
| trap_src | output | ID_W | Trapped requester |
| trap_ptrs | output | HW_PTRS*ID_W | All pointer slots, slot i at bits i*ID_W |
| trap_ptr_vld | output | HW_PTRS | Valid bit per slot |
| trap_done | input | 1 | Handler completion, held until trap_valid falls |
| trap_inv_cnt | input | CNT_W | Invalidations sent by software for a write trap |
| meta_state | output | 2 | 0 normal, 1 in transition, 2 writes trapped |
| line_rw | output | 1 | Line is held read-write by one owner |

## Verification
The bench builds the entry with twelve nodes and the default five pointer slots. The node count is not a power of two, so identifiers take four bits while several codes stay unused. Six distinct readers are enough to reach the overflow trap, and the full packed pointer bus can be compared against a hand-computed value. The same build takes the entry through hardware invalidation, owner recall, a read trap, hardware reads under trapped writes and a software-handled write, with retries injected during acknowledgement collection and during a trap.

// File: rtl/lpdir_pkg.sv
package lpdir_pkg;
   typedef enum logic [1:0] {
      META_NORMAL = 2'd0,
      META_TRANS  = 2'd1,
      META_TOW    = 2'd2
   } meta_e;

   typedef enum logic [1:0] {
      RSP_RDATA = 2'd0,
      RSP_WPERM = 2'd1,
      RSP_NACK  = 2'd2
   } rsp_e;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_COLLECT = 2'd1,
      PH_TRAP    = 2'd2
   } phase_e;
endpackage

// File: rtl/lpdir_ptr_store.sv
module lpdir_ptr_store #(
   parameter int SLOTS = 5,
   parameter int ID_W  = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ins_en,
   input  logic                  set_one,
   input  logic                  clr_all,
   input  logic [ID_W-1:0]       wr_id,
   input  logic [ID_W-1:0]       look_id,
   output logic [SLOTS*ID_W-1:0] ptrs_o,
   output logic [SLOTS-1:0]      vld_o,
   output logic [SLOTS-1:0]      hit_o,
   output logic                  full_o
);
   logic [SLOTS-1:0] free_vec;
   logic [SLOTS-1:0] ins_oh;

   assign free_vec = ~vld_o;
   assign ins_oh   = free_vec & (~free_vec + SLOTS'(1));
   assign full_o   = &vld_o;

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic [ID_W-1:0] id_q;
      logic            v_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            id_q <= '0;
            v_q  <= 1'b0;
         end else if (set_one) begin
            v_q  <= (g == 0);
            id_q <= (g == 0) ? wr_id : '0;
         end else if (clr_all) begin
            v_q  <= 1'b0;
         end else if (ins_en && ins_oh[g]) begin
            v_q  <= 1'b1;
            id_q <= wr_id;
         end
      end

      assign ptrs_o[g*ID_W +: ID_W] = id_q;
      assign vld_o[g]               = v_q;
      assign hit_o[g]               = v_q && (id_q == look_id);
   end

   AST_PTR_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hit_o) <= 1) else $error("duplicate pointer");            // R2
   AST_INS_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> !full_o) else $error("insert into full store");           // R3
endmodule

// File: rtl/lpdir_inv_seq.sv
module lpdir_inv_seq #(
   parameter int SLOTS = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SLOTS-1:0] load_mask,
   output logic [SLOTS-1:0] cur_oh,
   output logic             any
);
   logic [SLOTS-1:0] mask_q;

   assign cur_oh = mask_q & (~mask_q + SLOTS'(1));
   assign any    = |mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      mask_q <= '0;
      else if (load)   mask_q <= load_mask;
      else if (any)    mask_q <= mask_q & ~cur_oh;
   end

   AST_INV_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && any) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1))
      else $error("invalidation step skipped");                             // R7
endmodule

// File: rtl/lpdir_ack_ctr.sv
module lpdir_ack_ctr #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   assign zero = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (dec && !zero)  cnt_q <= cnt_q - CNT_W'(1);
   end

   AST_ACK_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load) |-> !zero) else $error("ack counter underflow");       // R8
endmodule

// File: rtl/lpdir_entry.sv
module lpdir_entry
   import lpdir_pkg::*;
#(
   parameter int NODES   = 16,
   parameter int HW_PTRS = 5,
   localparam int ID_W   = $clog2(NODES),
   localparam int CNT_W  = $clog2(NODES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic                    req_write,
   input  logic [ID_W-1:0]         req_src,
   output logic                    rsp_valid,
   output logic [1:0]              rsp_kind,
   output logic [ID_W-1:0]         rsp_dst,
   output logic                    inv_valid,
   output logic [ID_W-1:0]         inv_dst,
   input  logic                    ack_valid,
   output logic                    trap_valid,
   output logic                    trap_write,
   output logic [ID_W-1:0]         trap_src,
   output logic [HW_PTRS*ID_W-1:0] trap_ptrs,
   output logic [HW_PTRS-1:0]      trap_ptr_vld,
   input  logic                    trap_done,
   input  logic [CNT_W-1:0]        trap_inv_cnt,
   output logic [1:0]              meta_state,
   output logic                    line_rw
);
   if (NODES < 2) begin : g_bad_nodes
      $error("NODES must be at least 2");
   end
   if (HW_PTRS < 1 || HW_PTRS >= NODES) begin : g_bad_ptrs
      $error("HW_PTRS must lie in 1..NODES-1");
   end

   phase_e          phase_q, phase_n;
   meta_e           meta_q, meta_n;
   logic            rw_q, rw_n;
   logic [ID_W-1:0] src_q, src_n;
   logic            wr_q, wr_n;
   logic            rv_q;
   rsp_e            rk_q;
   logic [ID_W-1:0] rd_q;

   logic                    ins_en, set_one, clr_all;
   logic [ID_W-1:0]         wr_id;
   logic [HW_PTRS*ID_W-1:0] ptrs;
   logic [HW_PTRS-1:0]      vld, hit, victims, cur_oh;
   logic                    full, seq_any, seq_load;
   logic                    ack_load, ack_dec, ack_zero;
   logic [CNT_W-1:0]        ack_val;
   logic                    fire;
   rsp_e                    fk;
   logic [ID_W-1:0]         fd;

   lpdir_ptr_store #(.SLOTS(HW_PTRS), .ID_W(ID_W)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .set_one(set_one),
      .clr_all(clr_all), .wr_id(wr_id), .look_id(req_src),
      .ptrs_o(ptrs), .vld_o(vld), .hit_o(hit), .full_o(full)
   );

   lpdir_inv_seq #(.SLOTS(HW_PTRS)) u_seq (
      .clk(clk), .rst_n(rst_n), .load(seq_load), .load_mask(victims),
      .cur_oh(cur_oh), .any(seq_any)
   );

   lpdir_ack_ctr #(.CNT_W(CNT_W)) u_ack (
      .clk(clk), .rst_n(rst_n), .load(ack_load), .load_val(ack_val),
      .dec(ack_dec), .zero(ack_zero)
   );

   assign victims = vld & ~hit;
   assign ack_dec = ack_valid && (phase_q == PH_COLLECT);

   always_comb begin
      inv_dst = '0;
      for (int i = 0; i < HW_PTRS; i++) begin
         if (cur_oh[i]) inv_dst = inv_dst | ptrs[i*ID_W +: ID_W];
      end
   end
   assign inv_valid = (phase_q == PH_COLLECT) && seq_any;

   always_comb begin
      phase_n  = phase_q;
      meta_n   = meta_q;
      rw_n     = rw_q;
      src_n    = src_q;
      wr_n     = wr_q;
      ins_en   = 1'b0;
      set_one  = 1'b0;
      clr_all  = 1'b0;
      wr_id    = req_src;
      seq_load = 1'b0;
      ack_load = 1'b0;
      ack_val  = '0;
      fire     = 1'b0;
      fk       = RSP_NACK;
      fd       = req_src;
      unique case (phase_q)
         PH_IDLE: begin
            if (req_valid) begin
               src_n = req_src;
               wr_n  = req_write;
               if (meta_q == META_TOW && req_write) begin
                  phase_n = PH_TRAP;
                  meta_n  = META_TRANS;
               end else if (req_write || rw_q) begin
                  if (victims == '0) begin
                     fire = 1'b1;
                     fk   = req_write ? RSP_WPERM : RSP_RDATA;
                     if (req_write) begin
                        set_one = 1'b1;
                        rw_n    = 1'b1;
                     end
                  end else begin
                     seq_load = 1'b1;
                     ack_load = 1'b1;
                     ack_val  = CNT_W'($countones(victims));
                     phase_n  = PH_COLLECT;
                  end
               end else if (|hit) begin
                  fire = 1'b1;
                  fk   = RSP_RDATA;
               end else if (!full) begin
                  ins_en = 1'b1;
                  fire   = 1'b1;
                  fk     = RSP_RDATA;
               end else begin
                  phase_n = PH_TRAP;
                  meta_n  = META_TRANS;
               end
            end
         end
         PH_COLLECT: begin
            if (req_valid) begin
               fire = 1'b1;
            end else if (!seq_any && ack_zero) begin
               fire    = 1'b1;
               fd      = src_q;
               fk      = wr_q ? RSP_WPERM : RSP_RDATA;
               wr_id   = src_q;
               set_one = 1'b1;
               rw_n    = wr_q;
               phase_n = PH_IDLE;
            end
         end
         PH_TRAP: begin
            if (req_valid) begin
               fire = 1'b1;
            end else if (trap_done) begin
               clr_all = 1'b1;
               fd      = src_q;
               wr_id   = src_q;
               if (wr_q) begin
                  meta_n = META_NORMAL;
                  if (trap_inv_cnt == '0) begin
                     fire    = 1'b1;
                     fk      = RSP_WPERM;
                     set_one = 1'b1;
                     rw_n    = 1'b1;
                     phase_n = PH_IDLE;
                  end else begin
                     ack_load = 1'b1;
                     ack_val  = trap_inv_cnt;
                     phase_n  = PH_COLLECT;
                  end
               end else begin
                  meta_n  = META_TOW;
                  fire    = 1'b1;
                  fk      = RSP_RDATA;
                  phase_n = PH_IDLE;
               end
            end
         end
         default: phase_n = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         meta_q  <= META_NORMAL;
         rw_q    <= 1'b0;
         src_q   <= '0;
         wr_q    <= 1'b0;
         rv_q    <= 1'b0;
         rk_q    <= RSP_RDATA;
         rd_q    <= '0;
      end else begin
         phase_q <= phase_n;
         meta_q  <= meta_n;
         rw_q    <= rw_n;
         src_q   <= src_n;
         wr_q    <= wr_n;
         rv_q    <= fire;
         if (fire) begin
            rk_q <= fk;
            rd_q <= fd;
         end
      end
   end

   assign rsp_valid    = rv_q;
   assign rsp_kind     = rk_q;
   assign rsp_dst      = rd_q;
   assign trap_valid   = (phase_q == PH_TRAP);
   assign trap_write   = wr_q;
   assign trap_src     = src_q;
   assign trap_ptrs    = ptrs;
   assign trap_ptr_vld = vld;
   assign meta_state   = meta_q;
   assign line_rw      = rw_q;

   AST_TRAP_IN_TRANS: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> (meta_state == META_TRANS)) else $error("trap outside transition");   // R3
   AST_TRANS_NACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (meta_state == META_TRANS && req_valid) |=> (rsp_valid && rsp_kind == RSP_NACK))
      else $error("request not retried in transition");                                   // R4
   AST_INV_SKIPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> (inv_dst != src_q)) else $error("requester invalidated");             // R7
   AST_WPERM_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind == RSP_WPERM) |-> line_rw) else $error("grant without ownership"); // R8
   AST_RW_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      line_rw |-> ($countones(trap_ptr_vld) == 1)) else $error("owned line has many pointers"); // R8
endmodule

// File: tb/lpdir_entry_test.sv
module lpdir_entry_test;
   localparam int NODES = 12;
   localparam int NP    = 5;
   localparam int IW    = $clog2(NODES);
   localparam int CW    = $clog2(NODES + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [IW-1:0] req_src = '0;
   logic rsp_valid, inv_valid, trap_valid, trap_write, line_rw;
   logic [1:0] rsp_kind, meta_state;
   logic [IW-1:0] rsp_dst, inv_dst, trap_src;
   logic [NP*IW-1:0] trap_ptrs;
   logic [NP-1:0] trap_ptr_vld;
   logic ack_valid = 1'b0, trap_done = 1'b0;
   logic [CW-1:0] trap_inv_cnt = '0;

   int checks = 0, fails = 0;
   logic [IW+1:0] exp_rsp[$];
   logic [IW-1:0] exp_inv[$];

   always #10 clk = ~clk;

   lpdir_entry #(.NODES(NODES), .HW_PTRS(NP)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_src(req_src), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dst(rsp_dst),
      .inv_valid(inv_valid), .inv_dst(inv_dst), .ack_valid(ack_valid),
      .trap_valid(trap_valid), .trap_write(trap_write), .trap_src(trap_src),
      .trap_ptrs(trap_ptrs), .trap_ptr_vld(trap_ptr_vld), .trap_done(trap_done),
      .trap_inv_cnt(trap_inv_cnt), .meta_state(meta_state), .line_rw(line_rw)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor side of the scoreboard
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_rsp.size() == 0) chk("R2/R4/R8 unexpected reply", {rsp_kind, rsp_dst}, 0);
         else chk("R2/R4/R8 reply", {rsp_kind, rsp_dst}, exp_rsp.pop_front());
      end
      if (rst_n && inv_valid) begin
         if (exp_inv.size() == 0) chk("R7/R10 unexpected invalidation", inv_dst, 0);
         else chk("R7/R10 invalidation", inv_dst, exp_inv.pop_front());
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send(input logic wr, input int src, input int kind, input logic expect_rsp);
      if (expect_rsp) exp_rsp.push_back({kind[1:0], IW'(src)});
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_src = IW'(src);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic acks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ack_valid = 1'b1;
         @(negedge clk); ack_valid = 1'b0;
      end
   endtask

   task automatic done(input int cnt);
      @(negedge clk); trap_done = 1'b1; trap_inv_cnt = CW'(cnt);
      @(negedge clk); trap_done = 1'b0; trap_inv_cnt = '0;
   endtask

   initial begin
      #3000000;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      idle(3);
      chk("R1 rsp_valid", rsp_valid, 0);
      chk("R1 inv_valid", inv_valid, 0);
      chk("R1 trap_valid", trap_valid, 0);
      chk("R1 meta", meta_state, 0);
      chk("R1 line_rw", line_rw, 0);
      rst_n = 1'b1;
      idle(2);

      // R2: three readers and a repeat read
      send(0, 1, 0, 1); send(0, 2, 0, 1); send(0, 3, 0, 1); send(0, 2, 0, 1);
      idle(2);

      // R7 R8 R4: write from node 2, retry injected during collection
      exp_inv.push_back(IW'(1)); exp_inv.push_back(IW'(3));
      send(1, 2, 1, 0);
      send(0, 7, 2, 1);
      exp_rsp.push_back({2'd1, IW'(2)});
      acks(2);
      idle(3);
      chk("R8 line_rw after grant", line_rw, 1);

      // R10: owner reads its own line, then a recall by node 5
      send(0, 2, 0, 1);
      idle(1);
      chk("R10 owner keeps line_rw", line_rw, 1);
      exp_inv.push_back(IW'(2));
      send(0, 5, 0, 0);
      exp_rsp.push_back({2'd0, IW'(5)});
      acks(1);
      idle(3);
      chk("R10 recall clears line_rw", line_rw, 0);

      // R2 fill, R3 overflow trap
      send(0, 6, 0, 1); send(0, 7, 0, 1); send(0, 8, 0, 1); send(0, 9, 0, 1);
      send(0, 10, 0, 0);
      chk("R3 trap_valid", trap_valid, 1);
      chk("R3 trap_write", trap_write, 0);
      chk("R3 trap_src", trap_src, 10);
      chk("R3 ptr valids", trap_ptr_vld, 5'b11111);
      chk("R3 ptrs", trap_ptrs, {4'd9, 4'd8, 4'd7, 4'd6, 4'd5});
      chk("R3 meta in transition", meta_state, 1);
      chk("R3 no reply", rsp_valid, 0);
      send(0, 11, 2, 1);
      chk("R4 still trapped", trap_valid, 1);
      exp_rsp.push_back({2'd0, IW'(10)});
      done(0);
      chk("R5 trap dropped", trap_valid, 0);
      chk("R5 meta trap-on-write", meta_state, 2);
      idle(1);
      chk("R5 pointers emptied", trap_ptr_vld, 0);

      // R6: hardware read under trapped writes, then write trap
      send(0, 11, 0, 1);
      chk("R6 meta stays", meta_state, 2);
      chk("R6 slot0 valid", trap_ptr_vld, 5'b00001);
      send(1, 3, 0, 0);
      chk("R6 write trapped", trap_valid, 1);
      chk("R6 trap_write", trap_write, 1);
      chk("R6 trap_src", trap_src, 3);
      chk("R6 meta in transition", meta_state, 1);
      chk("R6 ptr0", trap_ptrs[IW-1:0], 11);

      // R9: software sent two invalidations
      done(2);
      chk("R9 meta normal", meta_state, 0);
      chk("R9 no early grant", rsp_valid, 0);
      exp_rsp.push_back({2'd1, IW'(3)});
      acks(2);
      idle(3);
      chk("R9 line_rw", line_rw, 1);

      // R10: owner write granted at once
      send(1, 3, 1, 1);
      idle(3);

      chk("scoreboard replies drained", exp_rsp.size(), 0);
      chk("scoreboard invalidations drained", exp_inv.size(), 0);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule